// File: doc/BRIEF.md
# Bridge Standby and Fault Supervisor

This block supervises two bridge controllers, each steered by a pair of logic command inputs. It watches all four command lines. When every line has stayed low for a programmable number of clock cycles it drops both bridges into a low-power standby. The first command line that rises ends the standby. A wake-up delay then follows, during which commands are still held back while the supply circuitry settles. After the delay the commands are honoured again.

The supervisor also applies protection, with every sensor taken as a digital flag. Each channel has its own overcurrent latch, which switches off only that channel. The latch is cleared only by leaving standby or by power-on reset. A thermal flag pair (hot and cooled) gives a shutdown with hysteresis that disables both bridges. A supply-good flag gives an undervoltage lockout that disables both bridges. The block outputs a per-channel disable, the command lines gated by that disable, a standby indication and a packed status word. Timer lengths are parameters in clock cycles.

Top module: `bridge_guard`

## Requirements
- R1: After power-on reset (rstN low) the block is active: standby is 0, every status bit is 0, chanOff is 0 and gatedCmd equals cmdIn while supplyOk is high.
- R2: When all four cmdIn lines are sampled low on IDLE_CYCLES consecutive clock edges, standby rises on the last of those edges. While standby is 1, chanOff is all ones and gatedCmd is zero.
- R3: A high cmdIn line on any edge before the idle count completes restarts the count from zero.
- R4: In standby, the edge that samples any cmdIn line high clears standby. The next WAKE_CYCLES cycles keep chanOff all ones and gatedCmd zero. After that, commands pass through.
- R5: cmdIn[1:0] belong to channel 0 and cmdIn[3:2] to channel 1. An ocFlag[c] sampled high while active sets that channel's latch on the same edge. The latch forces chanOff[c] to 1 and zeroes that channel's gatedCmd bits. The other channel is not affected.
- R6: An overcurrent latch stays set after its flag falls and through thermal and undervoltage events. It is cleared only on the edge that leaves standby or by reset. ocFlag has no effect while in standby or waking.
- R7: A hotFlag sampled high sets thermal shutdown, which forces both chanOff bits to 1. Shutdown holds until coolFlag is sampled high without hotFlag. When both are high, hotFlag wins. coolFlag has no effect when shutdown is not active.
- R8: A supplyOk sampled low forces both chanOff bits to 1 from the next cycle. The bridges are released one cycle after supplyOk is sampled high again.
- R9: status is packed as {standby, undervoltage, thermal, ocLatch[1], ocLatch[0]}, with bit 0 being ocLatch[0] and bit 4 being standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| cmdIn | input | 4 | Command lines, two per channel |
| ocFlag | input | 2 | Overcurrent flag per channel |
| hotFlag | input | 1 | Die above shutdown temperature |
| coolFlag | input | 1 | Die below release temperature |
| supplyOk | input | 1 | Load supply above lockout threshold |
| gatedCmd | output | 4 | Command lines after disable gating |
| chanOff | output | 2 | Per-channel bridge disable |
| standby | output | 1 | Low-power standby indication |
| status | output | 5 | Packed fault and state bits |

## Verification
The hardest state to reach from the ports is an overcurrent latch cleared by standby exit. To get there, a channel fault is latched, all commands are held low for the full idle window, and a command is then raised. The bench then checks that the latch is gone after the wake delay. The idle count is probed one edge short of its limit and then restarted, which pins the exact edge on which standby is entered. The wake window is sampled on its last gated cycle and on the first honoured cycle.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_WAKING  = 2'd2
  } guardState_t;

  typedef struct packed {
    logic idleInc;
    logic idleClr;
    logic wakeLoad;
    logic wakeDec;
    logic ocClear;
    logic ocArm;
  } guardStrobes_t;

endpackage

// File: rtl/bridge_guard_ctrl.sv
module bridge_guard_ctrl
  import bridge_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          anyHigh,
  input  logic          idleLast,
  input  logic          wakeZero,
  output guardStrobes_t strobes,
  output logic          running,
  output logic          inStandby
);

  guardState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_ACTIVE: begin
        strobes.ocArm = 1'b1;
        if (anyHigh) begin
          strobes.idleClr = 1'b1;
        end else if (idleLast) begin
          strobes.idleClr = 1'b1;
          stateNext       = ST_STANDBY;
        end else begin
          strobes.idleInc = 1'b1;
        end
      end
      ST_STANDBY: begin
        if (anyHigh) begin
          strobes.wakeLoad = 1'b1;
          strobes.ocClear  = 1'b1;
          stateNext        = ST_WAKING;
        end
      end
      ST_WAKING: begin
        strobes.idleClr = 1'b1;
        if (wakeZero) stateNext = ST_ACTIVE;
        else          strobes.wakeDec = 1'b1;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  assign running   = (state == ST_ACTIVE);
  assign inStandby = (state == ST_STANDBY);

  // R4: standby can never go straight to active without a wake window
  assert_no_skip_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY) |=> (state != ST_ACTIVE));

  // R2: standby is entered only from active
  assert_standby_from_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKING) |=> (state != ST_STANDBY));

endmodule

// File: rtl/bridge_guard_datapath.sv
module bridge_guard_datapath
  import bridge_guard_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int IDLE_CYCLES = 250000,
  parameter int WAKE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [NUM_CH-1:0] ocFlag,
  input  logic              hotFlag,
  input  logic              coolFlag,
  input  logic              supplyOk,
  output logic              idleLast,
  output logic              wakeZero,
  output logic [NUM_CH-1:0] ocLatch,
  output logic              thermalOff,
  output logic              uvloOff
);

  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [IDLE_W-1:0] idleCnt;
  logic [WAKE_W-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                idleCnt <= '0;
    else if (strobes.idleClr) idleCnt <= '0;
    else if (strobes.idleInc) idleCnt <= idleCnt + 1'b1;
  end

  assign idleLast = (idleCnt == IDLE_W'(IDLE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wakeCnt <= '0;
    else if (strobes.wakeLoad) wakeCnt <= WAKE_W'(WAKE_CYCLES - 1);
    else if (strobes.wakeDec)  wakeCnt <= wakeCnt - 1'b1;
  end

  assign wakeZero = (wakeCnt == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ocLatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             ocLatch[c] <= 1'b0;
      else if (strobes.ocClear)              ocLatch[c] <= 1'b0;
      else if (strobes.ocArm && ocFlag[c])   ocLatch[c] <= 1'b1;
    end

    // R6: a set latch survives unless a standby exit clears it
    assert_oc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ocLatch[c] && !strobes.ocClear) |=> ocLatch[c]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         thermalOff <= 1'b0;
    else if (hotFlag)  thermalOff <= 1'b1;
    else if (coolFlag) thermalOff <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uvloOff <= 1'b0;
    else       uvloOff <= !supplyOk;
  end

  // R3: idle count never passes its limit
  assert_idle_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_W'(IDLE_CYCLES - 1));

  // R7: hot flag always wins
  assert_hot_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |=> thermalOff);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bridge_guard_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int IDLE_CYCLES = 250000,
  parameter int WAKE_CYCLES = 50000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*NUM_CH-1:0] cmdIn,
  input  logic [NUM_CH-1:0]   ocFlag,
  input  logic                hotFlag,
  input  logic                coolFlag,
  input  logic                supplyOk,
  output logic [2*NUM_CH-1:0] gatedCmd,
  output logic [NUM_CH-1:0]   chanOff,
  output logic                standby,
  output logic [NUM_CH+2:0]   status
);

  guardStrobes_t     strobes;
  logic              idleLast, wakeZero, running, inStandby;
  logic              thermalOff, uvloOff;
  logic [NUM_CH-1:0] ocLatch;
  logic              anyHigh;

  assign anyHigh = |cmdIn;

  bridge_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyHigh   (anyHigh),
    .idleLast  (idleLast),
    .wakeZero  (wakeZero),
    .strobes   (strobes),
    .running   (running),
    .inStandby (inStandby)
  );

  bridge_guard_datapath #(
    .NUM_CH      (NUM_CH),
    .IDLE_CYCLES (IDLE_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ocFlag     (ocFlag),
    .hotFlag    (hotFlag),
    .coolFlag   (coolFlag),
    .supplyOk   (supplyOk),
    .idleLast   (idleLast),
    .wakeZero   (wakeZero),
    .ocLatch    (ocLatch),
    .thermalOff (thermalOff),
    .uvloOff    (uvloOff)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanOff[c]          = ocLatch[c] | thermalOff | uvloOff | !running;
    assign gatedCmd[2*c +: 2]  = chanOff[c] ? 2'b00 : cmdIn[2*c +: 2];
  end

  assign standby = inStandby;
  assign status  = {inStandby, uvloOff, thermalOff, ocLatch};

  // R2: both bridges are off throughout standby
  assert_standby_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (&chanOff));

  // R2: standby is entered only after idle inputs
  assert_entry_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |-> ($past(cmdIn) == '0));

  // R8: a low supply flag switches both bridges off on the next cycle
  assert_uvlo_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (&chanOff));

endmodule

// File: tb/bridge_guard_bench.sv
module bridge_guard_bench;

  localparam int IDLE = 20;
  localparam int WAKE = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] cmdIn;
  logic [1:0] ocFlag;
  logic       hotFlag, coolFlag, supplyOk;
  logic [3:0] gatedCmd;
  logic [1:0] chanOff;
  logic       standby;
  logic [4:0] status;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bridge_guard #(.NUM_CH(2), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) u_bridge_guard (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .ocFlag(ocFlag), .hotFlag(hotFlag),
    .coolFlag(coolFlag), .supplyOk(supplyOk), .gatedCmd(gatedCmd),
    .chanOff(chanOff), .standby(standby), .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdIn = 4'b0101; ocFlag = 2'b00;
    hotFlag = 1'b0; coolFlag = 1'b0; supplyOk = 1'b1;
    edges(3);
    rstN = 1'b1;
    edges(1);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 standby", standby, 0);
    chk("R1 status", status, 0);
    chk("R1 chanOff", chanOff, 0);
    chk("R1 gatedCmd", gatedCmd, 4'b0101);
  endtask

  task automatic testIdle();
    cmdIn = 4'b0000;
    edges(IDLE - 1);
    chk("R3 no standby one short", standby, 0);
    cmdIn = 4'b1000;
    edges(1);
    cmdIn = 4'b0000;
    edges(IDLE - 1);
    chk("R3 count restarted", standby, 0);
    edges(1);
    chk("R2 standby entered", standby, 1);
    chk("R2 chanOff in standby", chanOff, 2'b11);
    chk("R9 status standby", status, 5'b10000);
  endtask

  task automatic testWake(logic [3:0] pat);
    cmdIn = pat;
    edges(1);
    chk("R4 standby left", standby, 0);
    chk("R4 gated at wake start", gatedCmd, 0);
    edges(WAKE - 1);
    chk("R4 gated on last wake cycle", gatedCmd, 0);
    chk("R4 chanOff in wake", chanOff, 2'b11);
    edges(1);
    chk("R4 honoured after wake", gatedCmd, pat);
    chk("R4 chanOff released", chanOff, 2'b00);
  endtask

  task automatic testOc();
    cmdIn = 4'b1111;
    ocFlag = 2'b01;
    edges(1);
    ocFlag = 2'b00;
    chk("R5 ch0 off", chanOff, 2'b01);
    chk("R5 ch1 still runs", gatedCmd, 4'b1100);
    chk("R9 status oc0", status, 5'b00001);
    hotFlag = 1'b1; edges(1); hotFlag = 1'b0; coolFlag = 1'b1; edges(1); coolFlag = 1'b0;
    supplyOk = 1'b0; edges(1); supplyOk = 1'b1; edges(1);
    chk("R6 latch holds", status, 5'b00001);
    ocFlag = 2'b10; edges(1); ocFlag = 2'b00;
    chk("R5 ch1 latched too", chanOff, 2'b11);
    chk("R9 both oc bits", status, 5'b00011);
    // R6: latch cleared by standby exit; ocFlag ignored in standby and waking
    cmdIn = 4'b0000;
    edges(IDLE);
    chk("R6 standby reached", standby, 1);
    ocFlag = 2'b11; edges(2);
    cmdIn = 4'b0010; edges(1);
    chk("R6 cleared on exit", status[1:0], 0);
    edges(WAKE);
    ocFlag = 2'b00;
    chk("R6 flag ignored while asleep", status, 0);
    chk("R6 ch0 restored", gatedCmd, 4'b0010);
  endtask

  task automatic testResetClear();
    cmdIn = 4'b1111;
    ocFlag = 2'b10; edges(1); ocFlag = 2'b00;
    chk("R6 set before reset", status, 5'b00010);
    rstN = 1'b0; edges(1); rstN = 1'b1; edges(1);
    chk("R6 reset clears latch", status, 0);
  endtask

  task automatic testThermal();
    cmdIn = 4'b0110;
    coolFlag = 1'b1; edges(1); coolFlag = 1'b0;
    chk("R7 cool alone no effect", gatedCmd, 4'b0110);
    hotFlag = 1'b1; edges(1); hotFlag = 1'b0;
    chk("R7 shutdown", chanOff, 2'b11);
    chk("R9 status thermal", status, 5'b00100);
    edges(5);
    chk("R7 hysteresis hold", chanOff, 2'b11);
    hotFlag = 1'b1; coolFlag = 1'b1; edges(1);
    hotFlag = 1'b0;
    chk("R7 hot wins", chanOff, 2'b11);
    edges(1); coolFlag = 1'b0;
    chk("R7 released", chanOff, 2'b00);
    chk("R7 commands back", gatedCmd, 4'b0110);
  endtask

  task automatic testUvlo();
    cmdIn = 4'b1001;
    supplyOk = 1'b0; edges(1);
    chk("R8 lockout", chanOff, 2'b11);
    chk("R8 gated", gatedCmd, 0);
    chk("R9 status uvlo", status, 5'b01000);
    supplyOk = 1'b1; edges(1);
    chk("R8 release", gatedCmd, 4'b1001);
  endtask

  initial begin
    testReset();
    testIdle();
    testWake(4'b0100);
    testOc();
    testResetClear();
    testThermal();
    testUvlo();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule